// File: doc/BRIEF.md
# DDR2 Command Spacing Checker

This block observes a DDR2 command stream, one command per clock, each command carrying an operation code and a bank number. It holds saturating down-counters for every bank and for the whole rank. For each incoming command it checks every minimum-spacing rule that applies to that command. A command that arrives too early produces a one-cycle violation pulse, together with a code that names the broken rule. Every spacing limit is an input port counted in clock cycles, so one instance can serve any speed grade. The checks exist to catch a scheduler that issues commands too close together. The block does not move data, schedule refreshes or manage power-down.

A command that breaks a rule is still treated as issued: it restarts every timer it would normally start. The block can therefore sit beside a controller as a protocol monitor. It can also sit in front of a scheduler and gate permission to issue. When one command breaks several rules, the code reports the lowest-numbered rule. A sticky vector keeps every rule that has failed since reset or since it was last cleared.

Top module: `ddr2_cmd_timing_chk`

## Requirements
- R1: Operation encoding on `cmd_op`: 0 idle, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 refresh, 7 mode-register set. An idle cycle is never flagged and starts no timer. The verdict for a command presented in cycle c appears on `viol`/`viol_code` in cycle c+1. Spacing rule: if command A occurs in cycle a and a rule with limit N applies, a later command in cycle b breaks the rule exactly when b-a < N. A limit of 0 or 1 therefore never fails.
- R2: Rule 0 (row-to-column). A read or write to a bank breaks the rule if it comes less than `t_rcd` cycles after an activate to that same bank.
- R3: Rule 1 (active-to-precharge). A precharge to a bank breaks the rule if it comes less than `t_ras` cycles after an activate to that bank. A precharge-all is checked against every bank.
- R4: Rule 2 applies to a precharge less than `t_rtp` cycles after a read to the same bank. Rule 3 applies to a precharge less than `t_wr` cycles after a write to the same bank. A precharge-all is checked against all banks for both rules. The write limit counts from the write command, so it includes the burst.
- R5: Rule 4 applies to an activate less than `t_rc` cycles after an activate to the same bank. Rule 5 applies to an activate less than `t_rp` cycles after a precharge to that bank.
- R6: Rule 6 applies to any activate less than `t_rpa` cycles after a precharge-all.
- R7: Rule 7 applies to any activate less than `t_rrd` cycles after any other activate.
- R8: Rule 8 applies to a read less than `t_wtr` cycles after any write. Rule 9 applies to an activate or refresh less than `t_mrd` cycles after a mode-register set.
- R9: Rule 10 (four-activate window). An activate breaks the rule if the fourth-previous activate was less than `t_faw` cycles earlier.
- R10: Rule 11. Any command other than idle breaks the rule if it comes less than `t_rfc` cycles after a refresh.
- R11: When one command breaks several rules, `viol_code` gives the lowest rule number. `viol_code` is 0 when `viol` is low.
- R12: Bit k of `sticky` sets when rule k fails and holds until `clr_sticky` is high. A failure in the same cycle as a clear is kept.
- R13: When `rst_n` is low at a clock edge, the outputs and all timers return to zero. A command right after reset is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 3 | Command operation code (R1) |
| cmd_bank | input | 3 | Target bank |
| t_rcd | input | 8 | Activate to read/write, cycles |
| t_ras | input | 8 | Activate to precharge, cycles |
| t_rtp | input | 8 | Read to precharge, cycles |
| t_wr | input | 8 | Write to precharge, cycles |
| t_rc | input | 8 | Activate to activate, same bank |
| t_rp | input | 8 | Precharge to activate, same bank |
| t_rpa | input | 8 | Precharge-all to activate |
| t_rrd | input | 8 | Activate to activate, any bank |
| t_wtr | input | 8 | Write to read |
| t_mrd | input | 8 | Mode-register set to activate/refresh |
| t_faw | input | 8 | Four-activate window length |
| t_rfc | input | 8 | Refresh to any command |
| clr_sticky | input | 1 | Clear the sticky vector |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Lowest broken rule number |
| sticky | output | 12 | Accumulated failed rules |

## Verification
A timer that is stuck, loaded one cycle off, or attached to the wrong bank shows up directly at the ports. It either produces a violation pulse on the first command that a correct design accepts, or it stays silent on a command that should be flagged. The mismatch appears in the cycle after that command. An off-by-one load is exposed by commands placed exactly at the limit and one cycle before it. A wrong slot rotation in the four-activate window is exposed only on the fifth activate of a burst. A wrong priority order shows as a different code on commands that break two rules at once.

// File: rtl/ddr2_tc_pkg.sv
// Shared encodings for the DDR2 command spacing checker.
// Assumes one command per clock, with a 3-bit operation code.
package ddr2_tc_pkg;
    localparam int OPW    = 3;
    localparam int NRULES = 12;
    localparam int CW     = $clog2(NRULES);

    typedef enum logic [OPW-1:0] {
        OP_IDLE = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_PREA = 3'd5,
        OP_REF  = 3'd6,
        OP_MRS  = 3'd7
    } ddr2_op_e;

    // Rule numbers double as priority: lower wins.
    localparam int RULE_RCD = 0;
    localparam int RULE_RAS = 1;
    localparam int RULE_RTP = 2;
    localparam int RULE_WR  = 3;
    localparam int RULE_RC  = 4;
    localparam int RULE_RP  = 5;
    localparam int RULE_RPA = 6;
    localparam int RULE_RRD = 7;
    localparam int RULE_WTR = 8;
    localparam int RULE_MRD = 9;
    localparam int RULE_FAW = 10;
    localparam int RULE_RFC = 11;
endpackage

// File: rtl/ddr2_tc_downcnt.sv
// Saturating spacing timer.
// On load it takes the larger of (limit-1) and its own decremented value, so
// a second start never shortens a window that is still open. It counts down
// to zero and stops there. busy is high while a later command would be early.
// Assumes the limit is counted in clock cycles from the starting command.
module ddr2_tc_downcnt #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] lim,
    output logic          busy
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] dec;
    logic [TW-1:0] lim_m1;
    logic [TW-1:0] nxt;

    // Next value: decrement with saturation, then extend on load.
    always_comb begin
        dec    = (cnt == '0) ? '0 : cnt - TW'(1);
        lim_m1 = (lim == '0) ? '0 : lim - TW'(1);
        nxt    = dec;
        if (load && (lim_m1 > dec)) nxt = lim_m1;
    end

    // Timer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/ddr2_tc_bank.sv
// Timers for one bank.
// Holds the windows that only commands to this bank open: row-to-column,
// active-to-precharge and row cycle (started by activate), read-to-precharge
// (read), write recovery (write) and precharge-to-activate (precharge).
// Assumes the strobes are already qualified by the bank number.
module ddr2_tc_bank #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          rd,
    input  logic          wr,
    input  logic          pre,
    input  logic [TW-1:0] t_rcd,
    input  logic [TW-1:0] t_ras,
    input  logic [TW-1:0] t_rtp,
    input  logic [TW-1:0] t_wr,
    input  logic [TW-1:0] t_rc,
    input  logic [TW-1:0] t_rp,
    output logic          busy_rcd,
    output logic          busy_ras,
    output logic          busy_rtp,
    output logic          busy_wr,
    output logic          busy_rc,
    output logic          busy_rp
);
    ddr2_tc_downcnt #(.TW(TW)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act), .lim(t_rcd), .busy(busy_rcd));
    ddr2_tc_downcnt #(.TW(TW)) u_ras (.clk(clk), .rst_n(rst_n), .load(act), .lim(t_ras), .busy(busy_ras));
    ddr2_tc_downcnt #(.TW(TW)) u_rc  (.clk(clk), .rst_n(rst_n), .load(act), .lim(t_rc),  .busy(busy_rc));
    ddr2_tc_downcnt #(.TW(TW)) u_rtp (.clk(clk), .rst_n(rst_n), .load(rd),  .lim(t_rtp), .busy(busy_rtp));
    ddr2_tc_downcnt #(.TW(TW)) u_wr  (.clk(clk), .rst_n(rst_n), .load(wr),  .lim(t_wr),  .busy(busy_wr));
    ddr2_tc_downcnt #(.TW(TW)) u_rp  (.clk(clk), .rst_n(rst_n), .load(pre), .lim(t_rp),  .busy(busy_rp));
endmodule

// File: rtl/ddr2_tc_faw.sv
// Rolling activate window.
// Keeps one timer per remembered activate, NACT in total, in a ring. The slot
// under the pointer belongs to the oldest remembered activate. A new activate
// is early if that slot is still busy. The activate then restarts that slot
// and moves the pointer on.
// Assumes every activate, legal or not, counts toward the window.
module ddr2_tc_faw #(
    parameter int TW   = 8,
    parameter int NACT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic [TW-1:0] t_faw,
    output logic          busy
);
    localparam int PW = (NACT > 1) ? $clog2(NACT) : 1;

    logic [PW-1:0]   ptr;
    logic [NACT-1:0] slot_busy;

    for (genvar i = 0; i < NACT; i++) begin : g_slot
        ddr2_tc_downcnt #(.TW(TW)) u_slot (
            .clk  (clk),
            .rst_n(rst_n),
            .load (act && (ptr == PW'(i))),
            .lim  (t_faw),
            .busy (slot_busy[i])
        );
    end

    // Ring pointer advances once per activate.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ptr <= '0;
        else if (act && (ptr == PW'(NACT-1))) ptr <= '0;
        else if (act)                   ptr <= ptr + PW'(1);
    end

    assign busy = slot_busy[ptr];
endmodule

// File: rtl/ddr2_cmd_timing_chk.sv
// DDR2 command spacing checker (top).
// Decodes each command and checks it against the per-bank timers, the rank
// timers and the activate window. It registers a one-cycle violation pulse
// and the lowest broken rule number, and accumulates a sticky rule vector.
// Assumes one command per cycle, with limits given in cycles. A flagged
// command still starts its timers.
module ddr2_cmd_timing_chk
    import ddr2_tc_pkg::*;
#(
    parameter int NBANK    = 8,
    parameter int TW       = 8,
    parameter int FAW_ACTS = 4,
    parameter int BW       = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPW-1:0]    cmd_op,
    input  logic [BW-1:0]     cmd_bank,
    input  logic [TW-1:0]     t_rcd,
    input  logic [TW-1:0]     t_ras,
    input  logic [TW-1:0]     t_rtp,
    input  logic [TW-1:0]     t_wr,
    input  logic [TW-1:0]     t_rc,
    input  logic [TW-1:0]     t_rp,
    input  logic [TW-1:0]     t_rpa,
    input  logic [TW-1:0]     t_rrd,
    input  logic [TW-1:0]     t_wtr,
    input  logic [TW-1:0]     t_mrd,
    input  logic [TW-1:0]     t_faw,
    input  logic [TW-1:0]     t_rfc,
    input  logic              clr_sticky,
    output logic              viol,
    output logic [CW-1:0]     viol_code,
    output logic [NRULES-1:0] sticky
);
    logic is_act, is_rd, is_wr, is_pre, is_prea, is_ref, is_mrs, is_any;
    logic [NBANK-1:0] b_rcd, b_ras, b_rtp, b_wr, b_rc, b_rp;
    logic g_rpa, g_rrd, g_wtr, g_mrd, g_rfc, g_faw;
    logic [NRULES-1:0] fail;
    logic [CW-1:0]     code_n;

    // Command decode.
    always_comb begin
        is_act  = (cmd_op == OP_ACT);
        is_rd   = (cmd_op == OP_RD);
        is_wr   = (cmd_op == OP_WR);
        is_pre  = (cmd_op == OP_PRE);
        is_prea = (cmd_op == OP_PREA);
        is_ref  = (cmd_op == OP_REF);
        is_mrs  = (cmd_op == OP_MRS);
        is_any  = (cmd_op != OP_IDLE);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = (cmd_bank == BW'(b));
        ddr2_tc_bank #(.TW(TW)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act(is_act && hit), .rd(is_rd && hit),
            .wr(is_wr && hit),   .pre(is_pre && hit),
            .t_rcd(t_rcd), .t_ras(t_ras), .t_rtp(t_rtp),
            .t_wr(t_wr),   .t_rc(t_rc),   .t_rp(t_rp),
            .busy_rcd(b_rcd[b]), .busy_ras(b_ras[b]), .busy_rtp(b_rtp[b]),
            .busy_wr(b_wr[b]),   .busy_rc(b_rc[b]),   .busy_rp(b_rp[b])
        );
    end

    ddr2_tc_downcnt #(.TW(TW)) u_rpa (.clk(clk), .rst_n(rst_n), .load(is_prea), .lim(t_rpa), .busy(g_rpa));
    ddr2_tc_downcnt #(.TW(TW)) u_rrd (.clk(clk), .rst_n(rst_n), .load(is_act),  .lim(t_rrd), .busy(g_rrd));
    ddr2_tc_downcnt #(.TW(TW)) u_wtr (.clk(clk), .rst_n(rst_n), .load(is_wr),   .lim(t_wtr), .busy(g_wtr));
    ddr2_tc_downcnt #(.TW(TW)) u_mrd (.clk(clk), .rst_n(rst_n), .load(is_mrs),  .lim(t_mrd), .busy(g_mrd));
    ddr2_tc_downcnt #(.TW(TW)) u_rfc (.clk(clk), .rst_n(rst_n), .load(is_ref),  .lim(t_rfc), .busy(g_rfc));

    ddr2_tc_faw #(.TW(TW), .NACT(FAW_ACTS)) u_faw (
        .clk(clk), .rst_n(rst_n), .act(is_act), .t_faw(t_faw), .busy(g_faw)
    );

    // Per-rule failure flags for the current command.
    always_comb begin
        fail           = '0;
        fail[RULE_RCD] = (is_rd || is_wr) && b_rcd[cmd_bank];
        fail[RULE_RAS] = (is_pre && b_ras[cmd_bank]) || (is_prea && (|b_ras));
        fail[RULE_RTP] = (is_pre && b_rtp[cmd_bank]) || (is_prea && (|b_rtp));
        fail[RULE_WR]  = (is_pre && b_wr[cmd_bank])  || (is_prea && (|b_wr));
        fail[RULE_RC]  = is_act && b_rc[cmd_bank];
        fail[RULE_RP]  = is_act && b_rp[cmd_bank];
        fail[RULE_RPA] = is_act && g_rpa;
        fail[RULE_RRD] = is_act && g_rrd;
        fail[RULE_WTR] = is_rd && g_wtr;
        fail[RULE_MRD] = (is_act || is_ref) && g_mrd;
        fail[RULE_FAW] = is_act && g_faw;
        fail[RULE_RFC] = is_any && g_rfc;
    end

    // Priority encoder: lowest failing rule number.
    always_comb begin
        code_n = '0;
        for (int i = NRULES - 1; i >= 0; i--) begin
            if (fail[i]) code_n = CW'(i);
        end
    end

    // Registered verdict and sticky accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol      <= 1'b0;
            viol_code <= '0;
            sticky    <= '0;
        end else begin
            viol      <= |fail;
            viol_code <= code_n;
            sticky    <= (clr_sticky ? '0 : sticky) | fail;
        end
    end
endmodule

// File: rtl/ddr2_tc_checker.sv
// Property checker for the DDR2 command spacing checker. It is attached to
// the top module by the bind statement at the end of this file.
// Assumes the default parameters of the top module.
module ddr2_tc_checker
    import ddr2_tc_pkg::*;
#(
    parameter int TW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OPW-1:0]    cmd_op,
    input logic [TW-1:0]     t_rfc,
    input logic              clr_sticky,
    input logic              viol,
    input logic [CW-1:0]     viol_code,
    input logic [NRULES-1:0] sticky
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_IDLE) |=> !viol);

    assert_code_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (viol_code < CW'(NRULES)));

    assert_code_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !viol |-> (viol_code == '0));

    assert_code_recorded_R12: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (((sticky >> viol_code) & NRULES'(1)) != '0));

    assert_sticky_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_sticky |=> ((sticky & $past(sticky)) == $past(sticky)));

    assert_refresh_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_op == OP_REF) && (t_rfc > TW'(1))) ##1 (cmd_op != OP_IDLE) |=> viol);
endmodule

bind ddr2_cmd_timing_chk ddr2_tc_checker #(.TW(TW)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .t_rfc(t_rfc),
    .clr_sticky(clr_sticky), .viol(viol), .viol_code(viol_code), .sticky(sticky)
);

// File: tb/test_ddr2_cmd_timing_chk.sv
module test_ddr2_cmd_timing_chk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [2:0] cmd_bank = 3'd0;
    logic [7:0] t_rcd = 8'd2, t_ras = 8'd6, t_rtp = 8'd2, t_wr = 8'd3;
    logic [7:0] t_rc = 8'd8, t_rp = 8'd2, t_rpa = 8'd3, t_rrd = 8'd2;
    logic [7:0] t_wtr = 8'd2, t_mrd = 8'd2, t_faw = 8'd10, t_rfc = 8'd14;
    logic       clr_sticky = 1'b0;
    logic       viol;
    logic [3:0] viol_code;
    logic [11:0] sticky;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ddr2_cmd_timing_chk i_ddr2_cmd_timing_chk (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .t_rcd(t_rcd), .t_ras(t_ras), .t_rtp(t_rtp), .t_wr(t_wr),
        .t_rc(t_rc), .t_rp(t_rp), .t_rpa(t_rpa), .t_rrd(t_rrd),
        .t_wtr(t_wtr), .t_mrd(t_mrd), .t_faw(t_faw), .t_rfc(t_rfc),
        .clr_sticky(clr_sticky), .viol(viol), .viol_code(viol_code), .sticky(sticky)
    );

    // Vector: {gap idle cycles[8], op[3], bank[3], expected viol[1], expected code[4]}
    localparam int NV = 22;
    localparam logic [18:0] VEC [NV] = '{
        {8'd0,  3'd1, 3'd0, 1'b0, 4'd0},   // @0  ACT b0
        {8'd0,  3'd2, 3'd0, 1'b1, 4'd0},   // @1  RD b0 early: rcd
        {8'd0,  3'd2, 3'd0, 1'b0, 4'd0},   // @2  RD b0 at limit
        {8'd0,  3'd4, 3'd0, 1'b1, 4'd1},   // @3  PRE b0: ras+rtp, ras wins
        {8'd0,  3'd1, 3'd0, 1'b1, 4'd4},   // @4  ACT b0: rc+rp, rc wins
        {8'd20, 3'd1, 3'd1, 1'b0, 4'd0},   // @25 ACT b1
        {8'd0,  3'd1, 3'd2, 1'b1, 4'd7},   // @26 ACT b2: rrd
        {8'd1,  3'd1, 3'd3, 1'b0, 4'd0},   // @28 ACT b3
        {8'd1,  3'd1, 3'd4, 1'b0, 4'd0},   // @30 ACT b4
        {8'd1,  3'd1, 3'd5, 1'b1, 4'd10},  // @32 ACT b5: fifth in window
        {8'd10, 3'd1, 3'd6, 1'b0, 4'd0},   // @43 ACT b6
        {8'd0,  3'd3, 3'd1, 1'b0, 4'd0},   // @44 WR b1
        {8'd0,  3'd2, 3'd1, 1'b1, 4'd8},   // @45 RD b1: wtr
        {8'd0,  3'd4, 3'd1, 1'b1, 4'd2},   // @46 PRE b1: rtp+wr, rtp wins
        {8'd0,  3'd4, 3'd1, 1'b0, 4'd0},   // @47 PRE b1 at limits
        {8'd0,  3'd1, 3'd1, 1'b1, 4'd5},   // @48 ACT b1: rp
        {8'd2,  3'd5, 3'd0, 1'b1, 4'd1},   // @51 PREA: bank1 ras
        {8'd0,  3'd1, 3'd7, 1'b1, 4'd6},   // @52 ACT b7: rpa
        {8'd20, 3'd7, 3'd0, 1'b0, 4'd0},   // @73 MRS
        {8'd0,  3'd6, 3'd0, 1'b1, 4'd9},   // @74 REF: mrd
        {8'd5,  3'd2, 3'd3, 1'b1, 4'd11},  // @80 RD b3: rfc
        {8'd12, 3'd2, 3'd3, 1'b0, 4'd0}    // @93 RD b3 after rfc
    };

    function automatic string req_of(input logic v, input logic [3:0] code);
        if (!v) return "R1";
        case (code)
            4'd0:        return "R2";
            4'd1:        return "R3";
            4'd2, 4'd3:  return "R4";
            4'd4, 4'd5:  return "R5";
            4'd6:        return "R6";
            4'd7:        return "R7";
            4'd8, 4'd9:  return "R8";
            4'd10:       return "R9";
            default:     return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Present one command, then sample its verdict one cycle later.
    task automatic step(input logic [2:0] op, input logic [2:0] bank);
        cmd_op = op;
        cmd_bank = bank;
        @(negedge clk);
        cmd_op = 3'd0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(3'd0, 3'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=0", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13: reset state
        check("R13", "viol after reset", int'(viol), 0);
        check("R13", "code after reset", int'(viol_code), 0);
        check("R13", "sticky after reset", int'(sticky), 0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            logic [7:0] gap;
            logic [2:0] op, bank;
            logic ev;
            logic [3:0] ec;
            {gap, op, bank, ev, ec} = VEC[k];
            idle(int'(gap));
            step(op, bank);
            check(req_of(ev, ec), $sformatf("vec %0d viol", k), int'(viol), int'(ev));
            check(ev ? "R11" : "R1", $sformatf("vec %0d code", k), int'(viol_code), int'(ec));
        end

        // R12: every rule has failed by now
        check("R12", "sticky full", int'(sticky), 12'hFFF);
        clr_sticky = 1'b1;
        step(3'd0, 3'd0);
        clr_sticky = 1'b0;
        check("R12", "sticky cleared", int'(sticky), 0);

        // R10 and R12: refresh, then early refresh while clearing
        step(3'd6, 3'd0);
        check("R10", "first refresh", int'(viol), 0);
        clr_sticky = 1'b1;
        step(3'd6, 3'd0);
        clr_sticky = 1'b0;
        check("R10", "back-to-back refresh code", int'(viol_code), 11);
        check("R12", "set wins over clear", int'(sticky), 12'h800);
        step(3'd0, 3'd0);
        check("R1", "idle in refresh window", int'(viol), 0);

        // R7: a limit of 1 allows activates on consecutive cycles
        idle(20);
        t_rrd = 8'd1;
        step(3'd1, 3'd2);
        check("R7", "act with t_rrd=1", int'(viol), 0);
        step(3'd1, 3'd3);
        check("R7", "next-cycle act with t_rrd=1", int'(viol), 0);
        t_rrd = 8'd2;

        // R13: reset mid-window clears timers and sticky
        idle(20);
        step(3'd6, 3'd0);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R13", "sticky after mid reset", int'(sticky), 0);
        step(3'd2, 3'd0);
        check("R13", "command after reset not flagged", int'(viol), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule